// File: doc/BRIEF.md
# Memory Bitfield Operation Unit

This unit runs one bitfield operation on a field of 1 to 32 bits that sits at a signed bit offset from a byte address in big-endian, byte-wide memory. A single `start` pulse hands over the base address, the signed offset, the length, an insert value and an opcode. The unit works out which bytes the field covers and reads them one at a time. It then extracts, inserts, inverts, clears, sets or searches the field. For the modifying operations it writes the same bytes back.

Results come back as a 32-bit word together with a negative flag and a zero flag. The flags describe either the field as it was before the operation or the value that was inserted. A processor datapath uses this unit for bitfield instructions whose operand lives in memory. The memory side is a plain byte port: a strobe, a write enable and an address go out, and read data is valid on the cycle after a read strobe.

Top module: `bitfield_mem_unit`

## Requirements
- R1: A length input of 0 selects a 32-bit field; any other value n selects an n-bit field.
- R2: The offset is two's complement. The first byte address is the base plus floor(offset/8). The bit position inside that byte is offset mod 8, taken in 0..7, where position 0 is the most significant bit of the byte.
- R3: The unit reads exactly floor((offset+len-1)/8) - floor(offset/8) + 1 bytes (1 to 5). It reads them one access each, at consecutive ascending addresses, starting at the first byte address.
- R4: Opcodes 0 and 1 are read-only. Opcode 0 returns the field sign-extended to 32 bits. Opcode 1 returns the field zero-extended. Opcode 7 behaves like opcode 1.
- R5: Opcode 2 (insert) replaces the field with the low len bits of the insert value. The result is those bits zero-extended, and the flags are taken from them.
- R6: Opcodes 3, 4 and 5 invert, clear and set the field in that order. Each returns the old field zero-extended, and the flags are taken from the old field.
- R7: A modifying operation keeps every bit outside the field. It writes back exactly the bytes it read, in ascending address order.
- R8: Opcodes 0, 1, 6 and 7 issue no memory writes.
- R9: Opcode 6 (find first one) returns the offset plus the index of the first set bit, counted from the field's most significant bit. If the field is all zeros it returns the offset plus the length.
- R10: N equals the most significant bit of the flag-source field, and Z is 1 when that field is all zeros.
- R11: `done` is a one-cycle pulse. It comes after the last memory access and never in the same cycle as one. Result and flags hold until the next accepted start, and a `start` while `busy` is ignored.
- R12: After reset, `busy`, `done`, `mem_en` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| opcode | input | 3 | Operation select |
| base_addr | input | AW | Byte base address |
| bit_ofs | input | FW | Signed bit offset |
| fld_len | input | LW | Field length, 0 means 32 |
| ins_val | input | FW | Value for insert |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| result | output | FW | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read strobe |

## Verification
Several kinds of stimulus are used.
- Random opcodes, offsets from -150 to +150 and all raw lengths exercise every span from one to five bytes and negative offsets. A whole-memory comparison catches bytes that are written outside the span or bits that change outside the field.
- A 32-bit field at bit position 7 forces the widest span.
- Offsets of -1 and -8 separate correct floor rounding from truncation toward zero.
- Set-then-sign-extract and clear-then-search pairs place known contents in the field. They separate the sign fill, the all-zero search result and the inserted-value flags from the old-field flags.
- A second start pulse during an operation shows whether start is ignored while busy.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

    typedef enum logic [2:0] {
        OP_EXTS = 3'd0,
        OP_EXTU = 3'd1,
        OP_INS  = 3'd2,
        OP_CHG  = 3'd3,
        OP_CLR  = 3'd4,
        OP_SET  = 3'd5,
        OP_FFO  = 3'd6,
        OP_RSV  = 3'd7
    } bf_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_CAP,
        ST_CALC,
        ST_WR,
        ST_DONE
    } bf_st_e;

    function automatic logic op_writes(bf_op_e op);
        return (op == OP_INS) || (op == OP_CHG) || (op == OP_CLR) || (op == OP_SET);
    endfunction

endpackage

// File: rtl/bfm_span.sv
module bfm_span #(
    parameter int AW = 16,
    parameter int FW = 32,
    parameter int LW = 5,
    parameter int CW = 3
) (
    input  logic [AW-1:0] base,
    input  logic [FW-1:0] ofs,
    input  logic [LW-1:0] len_raw,
    output logic [AW-1:0] first_addr,
    output logic [2:0]    bit_pos,
    output logic [LW:0]   eff_len,
    output logic [CW-1:0] nbytes
);
    logic signed [FW-1:0] byte_step;
    logic [LW+1:0]        span_bits;

    always_comb begin
        byte_step  = $signed(ofs) >>> 3;
        first_addr = base + AW'(byte_step);
        bit_pos    = ofs[2:0];
        eff_len    = (len_raw == '0) ? (LW+1)'(FW) : {1'b0, len_raw};
        span_bits  = (LW+2)'(bit_pos) + (LW+2)'(eff_len) - (LW+2)'(1);
        nbytes     = CW'(span_bits >> 3) + CW'(1);
    end
endmodule

// File: rtl/bfm_alu.sv
module bfm_alu import bfm_pkg::*; #(
    parameter int FW   = 32,
    parameter int LW   = 5,
    parameter int WINW = 40
) (
    input  logic [WINW-1:0] win,
    input  logic [2:0]      bit_pos,
    input  logic [LW:0]     eff_len,
    input  bf_op_e          op,
    input  logic [FW-1:0]   ins_val,
    input  logic [FW-1:0]   ofs,
    output logic [WINW-1:0] new_win,
    output logic [FW-1:0]   result,
    output logic            flag_n,
    output logic            flag_z
);
    localparam int CNTW = LW + 1;

    logic [FW-1:0]   low_mask, fld, ins_fld, top_bit, aligned, sel_fld;
    logic [WINW-1:0] fmask, ins_win, win_sh;
    logic [CNTW-1:0] lz;
    logic            found;
    int              shl;

    always_comb begin
        shl      = WINW - int'(eff_len);
        low_mask = {FW{1'b1}} >> (FW - int'(eff_len));
        top_bit  = FW'(1) << (int'(eff_len) - 1);
        win_sh   = win << bit_pos;
        fld      = FW'(win_sh >> shl);
        fmask    = ({WINW{1'b1}} << shl) >> bit_pos;
        ins_fld  = ins_val & low_mask;
        ins_win  = (WINW'(ins_fld) << shl) >> bit_pos;
        aligned  = fld << (FW - int'(eff_len));

        lz    = CNTW'(eff_len);
        found = 1'b0;
        for (int i = FW - 1; i >= 0; i--) begin
            if (!found && aligned[i]) begin
                lz    = CNTW'(FW - 1 - i);
                found = 1'b1;
            end
        end

        sel_fld = (op == OP_INS) ? ins_fld : fld;
        flag_n  = |(sel_fld & top_bit);
        flag_z  = ~|sel_fld;

        new_win = win;
        result  = fld;
        case (op)
            OP_EXTS: result  = fld | ((|(fld & top_bit)) ? ~low_mask : '0);
            OP_INS: begin
                new_win = (win & ~fmask) | ins_win;
                result  = ins_fld;
            end
            OP_CHG:  new_win = win ^ fmask;
            OP_CLR:  new_win = win & ~fmask;
            OP_SET:  new_win = win | fmask;
            OP_FFO:  result  = ofs + FW'(lz);
            default: ;
        endcase
    end
endmodule

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit import bfm_pkg::*; #(
    parameter int AW = 16,
    parameter int FW = 32,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    opcode,
    input  logic [AW-1:0] base_addr,
    input  logic [FW-1:0] bit_ofs,
    input  logic [LW-1:0] fld_len,
    input  logic [FW-1:0] ins_val,
    output logic          busy,
    output logic          done,
    output logic [FW-1:0] result,
    output logic          flag_n,
    output logic          flag_z,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    localparam int MAXB = (FW + 6) / 8 + 1;
    localparam int WINW = MAXB * 8;
    localparam int CW   = $clog2(MAXB + 1);

    typedef struct packed {
        bf_st_e        st;
        logic [AW-1:0] addr;
        logic [2:0]    bpos;
        logic [LW:0]   len;
        logic [CW-1:0] nb;
        logic [CW-1:0] idx;
        bf_op_e        op;
        logic [FW-1:0] ofs;
        logic [FW-1:0] ins;
        logic [WINW-1:0] win;
        logic [FW-1:0] res;
        logic          n;
        logic          z;
    } regs_t;

    regs_t q, d;

    logic [AW-1:0]   sp_addr;
    logic [2:0]      sp_bpos;
    logic [LW:0]     sp_len;
    logic [CW-1:0]   sp_nb;
    logic [WINW-1:0] alu_win;
    logic [FW-1:0]   alu_res;
    logic            alu_n, alu_z;
    logic            last_byte;

    bfm_span #(.AW(AW), .FW(FW), .LW(LW), .CW(CW)) u_span (
        .base       (base_addr),
        .ofs        (bit_ofs),
        .len_raw    (fld_len),
        .first_addr (sp_addr),
        .bit_pos    (sp_bpos),
        .eff_len    (sp_len),
        .nbytes     (sp_nb)
    );

    bfm_alu #(.FW(FW), .LW(LW), .WINW(WINW)) u_alu (
        .win     (q.win),
        .bit_pos (q.bpos),
        .eff_len (q.len),
        .op      (q.op),
        .ins_val (q.ins),
        .ofs     (q.ofs),
        .new_win (alu_win),
        .result  (alu_res),
        .flag_n  (alu_n),
        .flag_z  (alu_z)
    );

    always_comb begin
        d         = q;
        last_byte = (q.idx == q.nb - CW'(1));
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_REQ;
                    d.addr = sp_addr;
                    d.bpos = sp_bpos;
                    d.len  = sp_len;
                    d.nb   = sp_nb;
                    d.idx  = '0;
                    d.op   = bf_op_e'(opcode);
                    d.ofs  = bit_ofs;
                    d.ins  = ins_val;
                    d.win  = '0;
                end
            end
            ST_REQ: d.st = ST_CAP;
            ST_CAP: begin
                d.win[(WINW - 1) - 8 * int'(q.idx) -: 8] = mem_rdata;
                if (last_byte) begin
                    d.st  = ST_CALC;
                    d.idx = '0;
                end else begin
                    d.st  = ST_REQ;
                    d.idx = q.idx + CW'(1);
                end
            end
            ST_CALC: begin
                d.win = alu_win;
                d.res = alu_res;
                d.n   = alu_n;
                d.z   = alu_z;
                d.st  = op_writes(q.op) ? ST_WR : ST_DONE;
            end
            ST_WR: begin
                if (last_byte) d.st = ST_DONE;
                else           d.idx = q.idx + CW'(1);
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = (q.st == ST_DONE);
    assign result    = q.res;
    assign flag_n    = q.n;
    assign flag_z    = q.z;
    assign mem_en    = (q.st == ST_REQ) || (q.st == ST_WR);
    assign mem_we    = (q.st == ST_WR);
    assign mem_addr  = q.addr + AW'(q.idx);
    assign mem_wdata = q.win[(WINW - 1) - 8 * int'(q.idx) -: 8];
endmodule

// File: rtl/bfm_chk.sv
module bfm_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic [2:0]    opcode,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          done
);
    logic [2:0]    op_cap;
    logic [3:0]    rd_cnt, wr_cnt;
    logic [AW-1:0] last_rd, last_wr;
    logic          have_rd, have_wr;
    logic          wr_op;

    assign wr_op = (op_cap >= 3'd2) && (op_cap <= 3'd5);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_cap  <= '0;
            rd_cnt  <= '0;
            wr_cnt  <= '0;
            last_rd <= '0;
            last_wr <= '0;
            have_rd <= 1'b0;
            have_wr <= 1'b0;
        end else if (start && !busy) begin
            op_cap  <= opcode;
            rd_cnt  <= '0;
            wr_cnt  <= '0;
            have_rd <= 1'b0;
            have_wr <= 1'b0;
        end else if (mem_en) begin
            if (mem_we) begin
                wr_cnt  <= wr_cnt + 4'd1;
                last_wr <= mem_addr;
                have_wr <= 1'b1;
            end else begin
                rd_cnt  <= rd_cnt + 4'd1;
                last_rd <= mem_addr;
                have_rd <= 1'b1;
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_en); // R11
    AST_READ_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && have_rd) |-> (mem_addr == last_rd + AW'(1))); // R3
    AST_WRITE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && have_wr) |-> (mem_addr == last_wr + AW'(1))); // R7
    AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> wr_op); // R8
    AST_WR_MATCH_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_op) |-> (wr_cnt == rd_cnt)); // R7
    AST_SPAN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_cnt >= 4'd1 && rd_cnt <= 4'd5)); // R3
endmodule

bind bitfield_mem_unit bfm_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .opcode   (opcode),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done)
);

// File: tb/tb_bitfield_mem_unit.sv
module tb_bitfield_mem_unit;
    localparam int AW = 16;

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [2:0]    opcode = '0;
    logic [AW-1:0] base_addr = '0;
    logic [31:0]   bit_ofs = '0, ins_val = '0;
    logic [4:0]    fld_len = '0;
    logic          busy, done, flag_n, flag_z, mem_en, mem_we;
    logic [31:0]   result;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          fill_we = 1'b0;
    logic [7:0]    fill_a = '0, fill_d = '0;
    logic [7:0]    mem [0:255];
    int            checks = 0, errors = 0;

    always #10 clk = ~clk;

    bitfield_mem_unit #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .base_addr(base_addr), .bit_ofs(bit_ofs), .fld_len(fld_len),
        .ins_val(ins_val), .busy(busy), .done(done), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (fill_we) mem[fill_a] <= fill_d;
        else if (mem_en) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(int b, int ofs, logic [4:0] lr, logic [2:0] op,
                          logic [31:0] iv, bit poke, string tag);
        logic [7:0]  ref_m [0:255];
        int          L, first, nb, rd_n, wr_n, cyc, bad;
        int          ra [8];
        int          wa [8];
        logic [31:0] fld, lm, sel, eres, held;
        bit          en, ez, fnd, seen, wop;
        for (int i = 0; i < 256; i++) ref_m[i] = mem[i];
        L   = (lr == 0) ? 32 : int'(lr);
        lm  = (L == 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 1);
        fld = '0;
        for (int i = 0; i < L; i++) begin
            int p;
            p   = ofs + i;
            fld = {fld[30:0], ref_m[b + (p >>> 3)][7 - (p & 7)]};
        end
        first = b + (ofs >>> 3);
        nb    = ((ofs + L - 1) >>> 3) - (ofs >>> 3) + 1;
        wop   = (op >= 3'd2) && (op <= 3'd5);
        sel   = (op == 3'd2) ? (iv & lm) : fld;
        en    = sel[L-1];
        ez    = (sel == 0);
        case (op)
            3'd0: eres = fld[L-1] ? (fld | ~lm) : fld;
            3'd2: eres = iv & lm;
            3'd6: begin
                eres = ofs + L;
                fnd  = 1'b0;
                for (int i = 0; i < L; i++)
                    if (!fnd && fld[L-1-i]) begin eres = ofs + i; fnd = 1'b1; end
            end
            default: eres = fld;
        endcase
        if (wop) begin
            for (int i = 0; i < L; i++) begin
                int p, ba, bi;
                logic nv;
                p  = ofs + i; ba = b + (p >>> 3); bi = 7 - (p & 7);
                case (op)
                    3'd2:    nv = iv[L-1-i];
                    3'd3:    nv = ~ref_m[ba][bi];
                    3'd4:    nv = 1'b0;
                    default: nv = 1'b1;
                endcase
                ref_m[ba][bi] = nv;
            end
        end
        @(negedge clk);
        start = 1'b1; opcode = op; base_addr = AW'(b); bit_ofs = ofs;
        fld_len = lr; ins_val = iv;
        @(negedge clk);
        start = 1'b0;
        rd_n = 0; wr_n = 0; cyc = 0; seen = 1'b0;
        while (!seen && cyc < 2000) begin
            if (mem_en) begin
                if (mem_we) begin if (wr_n < 8) wa[wr_n] = int'(mem_addr); wr_n++; end
                else        begin if (rd_n < 8) ra[rd_n] = int'(mem_addr); rd_n++; end
            end
            if (done) seen = 1'b1;
            else begin
                if (poke && cyc == 2) begin
                    start = 1'b1; opcode = 3'd5; bit_ofs = 0; fld_len = 5'd1;
                end else start = 1'b0;
                @(negedge clk);
                cyc++;
            end
        end
        start = 1'b0;
        check(seen, "R11 done seen", 32'(seen), 32'd1);
        check(result === eres, tag, result, eres);
        check(flag_n === en, "R10 flag N", 32'(flag_n), 32'(en));
        check(flag_z === ez, "R10 flag Z", 32'(flag_z), 32'(ez));
        check(rd_n == nb, "R3 read count", rd_n, nb);
        bad = 0;
        for (int i = 0; i < rd_n && i < 8; i++) if (ra[i] != first + i) bad++;
        check(bad == 0, "R2 read addresses from floor offset", ra[0], first);
        check(wr_n == (wop ? nb : 0), wop ? "R7 write count" : "R8 no writes", wr_n, wop ? nb : 0);
        bad = 0;
        for (int i = 0; i < wr_n && i < 8; i++) if (wa[i] != first + i) bad++;
        check(bad == 0, "R7 write addresses", wr_n > 0 ? wa[0] : 0, first);
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_m[i]) bad++;
        check(bad == 0, "R7 memory image", bad, 0);
        held = result;
        @(negedge clk);
        check(done === 1'b0, "R11 done pulse width", 32'(done), 0);
        check(result === held, "R11 result held", result, held);
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL R11 watchdog actual=%h expected=%h", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tags [8];
        tags = '{"R4", "R4", "R5", "R6", "R6", "R6", "R9", "R4"};
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            fill_we = 1'b1; fill_a = 8'(i); fill_d = 8'($urandom);
        end
        @(negedge clk);
        fill_we = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R12 reset busy/done", {busy, done}, 0);
        check(mem_en === 1'b0 && result === 0, "R12 reset mem_en/result", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && mem_en === 1'b0, "R12 idle after reset", {busy, mem_en}, 0);

        run_op(120, 7, 5'd0, 3'd1, 0, 0, "R1 len 0 is 32, five bytes");
        run_op(120, -1, 5'd4, 3'd0, 0, 0, "R2 offset -1");
        run_op(120, -8, 5'd8, 3'd1, 0, 0, "R2 offset -8");
        run_op(130, 3, 5'd5, 3'd5, 0, 0, "R6 set");
        run_op(130, 3, 5'd5, 3'd0, 0, 0, "R4 sign fill");
        run_op(130, 3, 5'd5, 3'd4, 0, 0, "R6 clear");
        run_op(130, 3, 5'd5, 3'd6, 0, 0, "R9 zero field");
        run_op(130, 3, 5'd5, 3'd2, 32'hFFFF_FFE4, 0, "R5 insert masks value");
        run_op(130, 3, 5'd5, 3'd6, 0, 0, "R9 first one");
        run_op(130, -13, 5'd1, 3'd2, 32'h1, 0, "R5 insert one bit");
        run_op(140, 21, 5'd11, 3'd3, 0, 0, "R6 change");
        run_op(140, 2, 5'd9, 3'd7, 0, 0, "R4 opcode 7");
        run_op(140, 5, 5'd20, 3'd1, 0, 1, "R11 start ignored while busy");

        for (int k = 0; k < 300; k++) begin
            int          b, o;
            logic [2:0]  op;
            b  = 100 + int'($urandom % 56);
            o  = int'($urandom % 301) - 150;
            op = 3'($urandom);
            run_op(b, o, 5'($urandom), op, $urandom, 0, tags[op]);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule